// File: doc/BRIEF.md
# EEPROM Write-Protection Gate

This block sits between the decoded strobe and address/data pins of a byte-wide non-volatile memory and its page-write logic. It decides, once per write strobe, whether the write may go on to programming. It applies three hardware guards. The first is a supply-good input, combined with a hold-off timer that starts when the supply becomes good. The second is a strobe-level inhibit. The third is a minimum-width filter on the combined CE/WE low pulse. A qualified write comes out as a single-cycle `wr_go` pulse, with the address and data that were present when the pulse qualified.

Behind the hardware guards is a software protection lock. It is clear after reset. It is set by a fixed three-write command prefix, and only after a write-cycle delay. Once the lock is set, the same prefix opens a load window. Inside that window the writes that follow, byte or page, are forwarded. Each forwarded write restarts the window. When no write arrives for the window length, the lock closes again. While the lock is set, a write that is not part of the prefix and does not fall inside an open window is discarded and flagged on `illegal_o`.

Top module: `eeprom_wr_guard`

## Requirements
- R1: No `wr_go` is produced while `supply_ok` is low, nor until `supply_ok` has been high for `HOLD_CYC` consecutive cycles.
- R2: A write is blocked whenever `oe_n` is low, `ce_n` is high or `we_n` is high.
- R3: An active strobe (`ce_n`=0, `we_n`=0, `oe_n`=1) that lasts fewer than `FILT_CYC` cycles is ignored. One lasting `FILT_CYC` cycles or more gives exactly one `wr_go` pulse. That pulse carries `addr`/`wdata` as sampled on the qualifying cycle.
- R4: After reset, `protected_o` is 0 and neither `wr_go` nor `illegal_o` is asserted.
- R5: While unprotected, every qualified write is forwarded, including the command writes.
- R6: The command prefix is three writes in order: address 15'h5555 with data 8'hAA, then 15'h2AAA with 8'h55, then 15'h5555 with 8'hA0. Completing it while unprotected raises `protected_o` `TWC_CYC` cycles after the third write qualifies. Once set, `protected_o` stays set until reset.
- R7: While protected with no window open, a write that is not the next expected prefix write is discarded. It is flagged by a one-cycle `illegal_o` pulse.
- R8: While protected, the writes that make up the prefix are consumed silently, with neither `wr_go` nor `illegal_o`.
- R9: While protected, after a complete prefix, each following write is forwarded if it comes within `LOAD_CYC` cycles of the previous one. Once `LOAD_CYC` cycles pass with no write, the lock closes and writes are illegal again.
- R10: A write that breaks the prefix part-way resets the detector. A later lone third command write is therefore illegal.
- R11: `wr_go` and `illegal_o` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply above write threshold |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| wr_go | output | 1 | One-cycle pulse: write forwarded to page logic |
| wr_addr | output | AW | Address of the forwarded write |
| wr_data | output | DW | Data of the forwarded write |
| protected_o | output | 1 | Software protection lock is set |
| illegal_o | output | 1 | One-cycle pulse: write discarded under protection |

## Verification
The bench builds the gate with `FILT_CYC`=3, `HOLD_CYC`=20, `TWC_CYC`=10 and `LOAD_CYC`=30. These short counts make it practical to write while the supply is still in hold-off, and to drive strobes one cycle shorter than the filter. They also let the bench watch protection arrive after the write-cycle delay and let a load window expire. With the command prefix left at its defaults, the bench can break the prefix at each stage and check that it relocks.

// File: rtl/eeprom_wr_guard_pkg.sv
package eeprom_wr_guard_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_state_t;

  // Strobe combination that requests a write.
  function automatic logic strobe_write(input logic ce_n, input logic we_n,
                                        input logic oe_n);
    return !ce_n && !we_n && oe_n;
  endfunction

  // Address and data both match a command step.
  function automatic logic cmd_hit(input logic [14:0] a, input logic [7:0] d,
                                   input logic [14:0] ca, input logic [7:0] cd);
    return (a == ca) && (d == cd);
  endfunction

endpackage

// File: rtl/eeprom_wr_guard_holdoff.sv
module eeprom_wr_guard_holdoff #(
  parameter int HOLD_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic pwr_ready
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !supply_ok) hold_cnt <= HOLD_LOAD;
    else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
  end

  assign pwr_ready = supply_ok && (hold_cnt == '0);
endmodule

// File: rtl/eeprom_wr_guard_filter.sv
module eeprom_wr_guard_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic evt
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic [FW-1:0] run_cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (!rst_n || !act) begin
      run_cnt <= '0;
      fired   <= 1'b0;
    end else if (!fired) begin
      if (run_cnt == LAST) fired   <= 1'b1;
      else                 run_cnt <= run_cnt + 1'b1;
    end
  end

  assign evt = act && !fired && (run_cnt == LAST);
endmodule

// File: rtl/eeprom_wr_guard_sdp.sv
module eeprom_wr_guard_sdp
  import eeprom_wr_guard_pkg::*;
#(
  parameter int          TWC_CYC  = 10,
  parameter int          LOAD_CYC = 30,
  parameter logic [14:0] CMD0_A   = 15'h5555,
  parameter logic [7:0]  CMD0_D   = 8'hAA,
  parameter logic [14:0] CMD1_A   = 15'h2AAA,
  parameter logic [7:0]  CMD1_D   = 8'h55,
  parameter logic [14:0] CMD2_A   = 15'h5555,
  parameter logic [7:0]  CMD2_D   = 8'hA0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt,
  input  logic [14:0] ev_addr,
  input  logic [7:0]  ev_data,
  output logic        pass,
  output logic        ill,
  output logic        prot
);
  localparam int TW = $clog2(TWC_CYC + 1);
  localparam int LW = $clog2(LOAD_CYC + 1);
  localparam logic [TW-1:0] TWC_LOAD  = TW'(TWC_CYC);
  localparam logic [LW-1:0] LOAD_INIT = LW'(LOAD_CYC);

  seq_state_t    st, st_nx;
  logic [TW-1:0] arm_cnt;
  logic [LW-1:0] open_cnt;
  logic          arming;
  logic          hit0, hit1, hit2, seq_done;

  assign hit0 = cmd_hit(ev_addr, ev_data, CMD0_A, CMD0_D);
  assign hit1 = cmd_hit(ev_addr, ev_data, CMD1_A, CMD1_D);
  assign hit2 = cmd_hit(ev_addr, ev_data, CMD2_A, CMD2_D);

  always_comb begin
    st_nx    = st;
    pass     = 1'b0;
    ill      = 1'b0;
    seq_done = 1'b0;
    if (evt) begin
      unique case (st)
        SEQ_IDLE: begin
          pass = !prot;
          if (hit0) st_nx = SEQ_ONE;
          else      ill   = prot;
        end
        SEQ_ONE: begin
          pass = !prot;
          if (hit1) st_nx = SEQ_TWO;
          else begin st_nx = SEQ_IDLE; ill = prot; end
        end
        SEQ_TWO: begin
          pass = !prot;
          if (hit2) begin st_nx = SEQ_OPEN; seq_done = 1'b1; end
          else begin st_nx = SEQ_IDLE; ill = prot; end
        end
        SEQ_OPEN: pass = 1'b1;
        default:  st_nx = SEQ_IDLE;
      endcase
    end else if (st == SEQ_OPEN && open_cnt == LW'(1)) begin
      st_nx = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      open_cnt <= '0;
      arm_cnt  <= '0;
      arming   <= 1'b0;
      prot     <= 1'b0;
    end else begin
      st <= st_nx;
      if (seq_done || (evt && st == SEQ_OPEN)) open_cnt <= LOAD_INIT;
      else if (open_cnt != '0)                 open_cnt <= open_cnt - 1'b1;
      if (seq_done && !prot && !arming) begin
        arming  <= 1'b1;
        arm_cnt <= TWC_LOAD;
      end else if (arming) begin
        if (arm_cnt <= TW'(1)) begin
          arming <= 1'b0;
          prot   <= 1'b1;
        end
        arm_cnt <= arm_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard
  import eeprom_wr_guard_pkg::*;
#(
  parameter int          AW       = 15,
  parameter int          DW       = 8,
  parameter int          HOLD_CYC = 1000000,
  parameter int          FILT_CYC = 3,
  parameter int          TWC_CYC  = 2000000,
  parameter int          LOAD_CYC = 30000,
  parameter logic [14:0] CMD0_A   = 15'h5555,
  parameter logic [7:0]  CMD0_D   = 8'hAA,
  parameter logic [14:0] CMD1_A   = 15'h2AAA,
  parameter logic [7:0]  CMD1_D   = 8'h55,
  parameter logic [14:0] CMD2_A   = 15'h5555,
  parameter logic [7:0]  CMD2_D   = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          protected_o,
  output logic          illegal_o
);
  logic pwr_ready, strobe_act, evt, pass, ill;

  eeprom_wr_guard_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_ready(pwr_ready));

  assign strobe_act = pwr_ready && strobe_write(ce_n, we_n, oe_n);

  eeprom_wr_guard_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .act(strobe_act), .evt(evt));

  eeprom_wr_guard_sdp #(
    .TWC_CYC(TWC_CYC), .LOAD_CYC(LOAD_CYC),
    .CMD0_A(CMD0_A), .CMD0_D(CMD0_D), .CMD1_A(CMD1_A), .CMD1_D(CMD1_D),
    .CMD2_A(CMD2_A), .CMD2_D(CMD2_D)
  ) u_sdp (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .ev_addr(15'(addr)), .ev_data(8'(wdata)),
    .pass(pass), .ill(ill), .prot(protected_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_go     <= 1'b0;
      illegal_o <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_go     <= pass;
      illegal_o <= ill;
      if (pass) begin
        wr_addr <= addr;
        wr_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/eeprom_wr_guard_chk.sv
module eeprom_wr_guard_chk #(
  parameter int HOLD_CYC = 20,
  parameter int FILT_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic wr_go,
  input logic illegal_o,
  input logic protected_o
);
  int unsigned ok_run, act_run;
  logic strobe_on;

  assign strobe_on = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_run  <= 0;
      act_run <= 0;
    end else begin
      if (!supply_ok)                        ok_run <= 0;
      else if (ok_run <= HOLD_CYC)           ok_run <= ok_run + 1;
      if (!strobe_on)                        act_run <= 0;
      else if (act_run <= FILT_CYC)          act_run <= act_run + 1;
    end
  end

  assert_holdoff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> ok_run >= HOLD_CYC);
  assert_strobe_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(strobe_on));
  assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> act_run >= FILT_CYC);
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    protected_o |=> protected_o);
  assert_illegal_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> protected_o);
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_go, illegal_o}) <= 1);
endmodule

bind eeprom_wr_guard eeprom_wr_guard_chk #(.HOLD_CYC(HOLD_CYC), .FILT_CYC(FILT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
  .oe_n(oe_n), .wr_go(wr_go), .illegal_o(illegal_o), .protected_o(protected_o));

// File: tb/eeprom_wr_guard_test.sv
`timescale 1ns/1ps
module eeprom_wr_guard_test;
  localparam int HOLD = 20, FILT = 3, TWC = 10, LOAD = 30;
  localparam int K_GO = 1, K_ILL = 2;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr_go, protected_o, illegal_o;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0, errors = 0;
  int q_kind[$];
  logic [14:0] q_addr[$];
  logic [7:0]  q_data[$];
  string q_req[$];

  always #2.5 clk = ~clk;

  eeprom_wr_guard #(.HOLD_CYC(HOLD), .FILT_CYC(FILT), .TWC_CYC(TWC), .LOAD_CYC(LOAD)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .wr_go(wr_go), .wr_addr(wr_addr),
    .wr_data(wr_data), .protected_o(protected_o), .illegal_o(illegal_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the gate reports an event.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_go && illegal_o) check(1'b0, "R11 go/illegal overlap", 1, 0);
      else if (wr_go || illegal_o) begin
        if (q_kind.size() == 0)
          check(1'b0, "unexpected event", wr_go ? K_GO : K_ILL, 0);
        else begin
          automatic int k = q_kind.pop_front();
          automatic logic [14:0] ea = q_addr.pop_front();
          automatic logic [7:0] ed = q_data.pop_front();
          automatic string r = q_req.pop_front();
          check(k == (wr_go ? K_GO : K_ILL), {r, " kind"}, wr_go ? K_GO : K_ILL, k);
          if (wr_go && k == K_GO) check({wr_addr, wr_data} == {ea, ed}, {r, " addr/data"},
                                        {wr_addr, wr_data}, {ea, ed});
        end
      end
    end
  end

  // Driver: one strobe pulse, expectation queued first; kind 0 means no event.
  task automatic wr(input logic [14:0] a, input logic [7:0] d, input int len,
                    input int kind, input string req,
                    input logic ce_v = 1'b0, input logic we_v = 1'b0, input logic oe_v = 1'b1);
    if (kind != 0) begin
      q_kind.push_back(kind); q_addr.push_back(a); q_data.push_back(d); q_req.push_back(req);
    end
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce_v; we_n = we_v; oe_n = oe_v;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    check(q_kind.size() == 0, {req, " event missing"}, q_kind.size(), 0);
    q_kind.delete(); q_addr.delete(); q_data.delete(); q_req.delete();
  endtask

  task automatic prefix(input int kind, input string req);
    wr(15'h5555, 8'hAA, 4, kind, req);
    wr(15'h2AAA, 8'h55, 4, kind, req);
    wr(15'h5555, 8'hA0, 4, kind, req);
  endtask

  initial begin
    #(200000 * 5.0);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(protected_o == 1'b0, "R4 protected after reset", protected_o, 0);
    check(wr_go == 1'b0 && illegal_o == 1'b0, "R4 outputs idle", {wr_go, illegal_o}, 0);

    wr(15'h0010, 8'h11, 5, 0, "R1 supply low");
    supply_ok = 1'b1;
    wr(15'h0011, 8'h12, 5, 0, "R1 within hold-off");
    repeat (HOLD + 5) @(negedge clk);
    wr(15'h0012, 8'h13, 5, K_GO, "R5 plain write");

    wr(15'h0020, 8'h21, 5, 0, "R2 oe low", 1'b0, 1'b0, 1'b0);
    wr(15'h0021, 8'h22, 5, 0, "R2 we high", 1'b0, 1'b1, 1'b1);
    wr(15'h0022, 8'h23, 5, 0, "R2 ce high", 1'b1, 1'b0, 1'b1);

    wr(15'h0030, 8'h31, FILT - 1, 0, "R3 short pulse");
    wr(15'h0031, 8'h32, FILT, K_GO, "R3 minimum pulse");
    wr(15'h0032, 8'h33, 12, K_GO, "R3 long pulse once");

    prefix(K_GO, "R5 command forwarded");
    check(protected_o == 1'b0, "R6 not yet protected", protected_o, 0);
    repeat (TWC) @(negedge clk);
    check(protected_o == 1'b1, "R6 protected after delay", protected_o, 1);

    repeat (LOAD + 5) @(negedge clk);
    wr(15'h0040, 8'h41, 4, K_ILL, "R7 locked write");

    wr(15'h5555, 8'hAA, 4, 0, "R8 command silent");
    wr(15'h2AAA, 8'h55, 4, 0, "R8 command silent");
    wr(15'h0041, 8'h42, 4, K_ILL, "R10 broken prefix");
    wr(15'h5555, 8'hA0, 4, K_ILL, "R10 lone third command");

    prefix(0, "R8 prefix silent");
    wr(15'h0100, 8'h5A, 4, K_GO, "R9 first unlocked");
    wr(15'h0101, 8'hA5, 4, K_GO, "R9 page byte");
    repeat (LOAD + 5) @(negedge clk);
    wr(15'h0102, 8'h77, 4, K_ILL, "R9 window closed");
    check(protected_o == 1'b1, "R6 lock sticky", protected_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule